// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Mailboxes

This block links two ports, A and B. Each port runs on its own free-running clock, and the two clocks may be unrelated or identical. Two independent queues of 36-bit words run in opposite directions. Direction 1 carries words written at port A to reads at port B. Direction 2 carries words written at port B to reads at port A. Each direction also has a one-word mailbox. A mailbox word skips the queue, and a flag on the receiving port says that a word is waiting.

Both ports use the same control set:

- an active-low select;
- an enable;
- a write/read direction bit;
- a mailbox select.

Each port has a data input and a data output. A separate output-enable says when the port would drive a shared bus.

Every status flag on a port is registered in that port's clock. Queue pointers cross clock domains as Gray codes through two-flop synchronisers. A mode input chooses between two timings:

- **Standard timing:** a read loads the output register after the read edge.
- **Fall-through timing:** the oldest word appears on the output without any request.

The almost-full and almost-empty thresholds of a direction are loaded while that direction's reset is held.

Top module: `bidir_mail_fifo`

## Requirements
- R1: Words written at port A (select low, enable high, write bit 1, mailbox select 0 on a port A clock edge) come out at port B in the order they were written, with none lost or repeated.
- R2: Words written at port B come out at port A in the order they were written, independently of direction 1.
- R3: `*_in_ok` falls when the sending queue holds DEPTH words. A further queue write while it is low is dropped: that word never appears at the receiving port.
- R4: In standard mode, a queue read while `*_out_ok` is low changes neither the output word nor the queue contents. In this mode `*_out_ok` high means the queue is not empty.
- R5: In fall-through mode (`fwft` = 1), `*_out_ok` rises and the oldest word is already on the receiving `*_dout` before any read. A read moves the output to the next word, and `*_out_ok` stays high until the word shown has been read.
- R6: The threshold of a direction is loaded while its reset is low, from `fs_sel`:
  - 00 gives 16 words;
  - 01 gives 64 words;
  - 10 gives 8 words;
  - 11 gives 8 words.

  The sender's `*_afull` is high when level + threshold >= DEPTH. The receiver's `*_aempty` is high when level <= threshold.
- R7: A mailbox write (mailbox select 1, write bit 1) sets the receiving port's `*_mail_wait`. A mailbox read there (mailbox select 1, write bit 0) returns the word on `*_dout` while mailbox select is held, clears `*_mail_wait` on the next edge, and leaves the queue untouched.
- R8: A mailbox write made while the previous mailbox word of that direction is still unread is dropped.
- R9: While `rst1_n` is low, direction 1 and its mailbox are cleared: the queue is empty, in_ok is high, aempty is high, afull is low and no mail is waiting. `rst2_n` does the same for direction 2. Neither reset disturbs the other direction.
- R10: `*_oe` is high exactly when the port's select is low and its write bit is 0, regardless of enable.
- R11: No access takes place on a clock edge where the port's select is high or its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Active-low reset of direction A to B and its mailbox |
| rst2_n | input | 1 | Active-low reset of direction B to A and its mailbox |
| fwft | input | 1 | 1 = fall-through timing, 0 = standard; changed only under reset |
| fs_sel | input | 2 | Threshold select, loaded during reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | WIDTH | Port A write data |
| a_dout | output | WIDTH | Port A read data (mailbox when a_mbx = 1) |
| a_oe | output | 1 | Port A bus drive enable |
| a_in_ok | output | 1 | Direction 1 can accept a word |
| a_afull | output | 1 | Direction 1 almost full |
| a_out_ok | output | 1 | Direction 2 has a word for port A |
| a_aempty | output | 1 | Direction 2 almost empty |
| a_mail_wait | output | 1 | Mailbox of direction 2 holds a word |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | WIDTH | Port B write data |
| b_dout | output | WIDTH | Port B read data (mailbox when b_mbx = 1) |
| b_oe | output | 1 | Port B bus drive enable |
| b_in_ok | output | 1 | Direction 2 can accept a word |
| b_afull | output | 1 | Direction 2 almost full |
| b_out_ok | output | 1 | Direction 1 has a word for port B |
| b_aempty | output | 1 | Direction 1 almost empty |
| b_mail_wait | output | 1 | Mailbox of direction 1 holds a word |

## Verification
The bench builds the block with WIDTH 36 and DEPTH 32. A queue can then be filled to full, pushed past full and drained in a few dozen writes. The 8- and 16-word thresholds then sit at distinct, reachable levels on both flags. The two port clocks have unrelated periods, so each flag's synchroniser delay and each mailbox handshake is crossed at a varying phase. Both timing modes are covered, each selected under reset.

// File: rtl/bidir_mail_fifo.sv
`timescale 1ns/1ps
module bidir_mail_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst1_n,
  input  logic             rst2_n,
  input  logic             fwft,
  input  logic [1:0]       fs_sel,
  input  logic             a_cs_n,
  input  logic             a_en,
  input  logic             a_wr,
  input  logic             a_mbx,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_oe,
  output logic             a_in_ok,
  output logic             a_afull,
  output logic             a_out_ok,
  output logic             a_aempty,
  output logic             a_mail_wait,
  input  logic             b_cs_n,
  input  logic             b_en,
  input  logic             b_wr,
  input  logic             b_mbx,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_oe,
  output logic             b_in_ok,
  output logic             b_afull,
  output logic             b_out_ok,
  output logic             b_aempty,
  output logic             b_mail_wait
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [7:0] thresh(input logic [1:0] s);
    case (s)
      2'b00:   return 8'd16;
      2'b01:   return 8'd64;
      default: return 8'd8;
    endcase
  endfunction

  // index 0 = port A / direction A->B, index 1 = port B / direction B->A
  logic [1:0] clk, rstn, cs_n, en, wr, mbx, acc;
  logic [WIDTH-1:0] din [2];
  logic [WIDTH-1:0] fq [2];
  logic [WIDTH-1:0] mq [2];
  logic [1:0] full, afull, ordy, aempty, mwait;

  assign clk  = {clk_b, clk_a};
  assign rstn = {rst2_n, rst1_n};
  assign cs_n = {b_cs_n, a_cs_n};
  assign en   = {b_en, a_en};
  assign wr   = {b_wr, a_wr};
  assign mbx  = {b_mbx, a_mbx};
  assign acc  = ~cs_n & en;
  assign din[0] = a_din;
  assign din[1] = b_din;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int R = 1 - d;
    logic wr_f, wr_m, rd_f, rd_m, push, pop, avail, ov;
    logic [PW-1:0] wbin, wnext, wgray, rbin, rnext, rgray;
    logic [PW-1:0] rg1, rg2, wg1, wg2, wsync, wlvl, rlvl;
    logic [7:0] off;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] head, mreg, mout;
    logic wt, wt1, wt2, rt, rt1, rt2;

    assign wr_f = acc[d] & wr[d] & ~mbx[d];
    assign wr_m = acc[d] & wr[d] & mbx[d];
    assign rd_f = acc[R] & ~wr[R] & ~mbx[R];
    assign rd_m = acc[R] & ~wr[R] & mbx[R];

    // writer side
    assign wlvl    = wbin - gray2bin(rg2);
    assign full[d] = wlvl == PW'(DEPTH);
    assign afull[d] = 32'(wlvl) + 32'(off) >= DEPTH;
    assign push    = wr_f & ~full[d];
    assign wnext   = wbin + 1'b1;

    always_ff @(posedge clk[d] or negedge rstn[d])
      if (!rstn[d]) begin
        wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
      end else begin
        rg1 <= rgray;
        rg2 <= rg1;
        if (push) begin
          wbin  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end

    always_ff @(posedge clk[d]) if (push) mem[wbin[AW-1:0]] <= din[d];
    always_ff @(posedge clk[d]) if (!rstn[d]) off <= thresh(fs_sel);

    // reader side
    assign wsync     = gray2bin(wg2);
    assign avail     = wsync != rbin;
    assign pop       = avail & (fwft ? (~ov | rd_f) : rd_f);
    assign rnext     = rbin + 1'b1;
    assign rlvl      = wsync - rbin + PW'(fwft & ov);
    assign aempty[d] = 32'(rlvl) <= 32'(off);
    assign ordy[d]   = fwft ? ov : avail;
    assign fq[d]     = head;

    always_ff @(posedge clk[R] or negedge rstn[d])
      if (!rstn[d]) begin
        rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0; ov <= 1'b0;
      end else begin
        wg1 <= wgray;
        wg2 <= wg1;
        if (pop) begin
          rbin  <= rnext;
          rgray <= rnext ^ (rnext >> 1);
        end
        if (pop) ov <= 1'b1;
        else if (rd_f) ov <= 1'b0;
      end

    always_ff @(posedge clk[R]) if (pop) head <= mem[rbin[AW-1:0]];

    // mailbox: toggle handshake, one word in flight
    always_ff @(posedge clk[d] or negedge rstn[d])
      if (!rstn[d]) begin
        wt <= 1'b0; rt1 <= 1'b0; rt2 <= 1'b0;
      end else begin
        rt1 <= rt;
        rt2 <= rt1;
        if (wr_m && wt == rt2) wt <= ~wt;
      end

    always_ff @(posedge clk[d]) if (wr_m && wt == rt2) mreg <= din[d];

    assign mwait[d] = wt2 ^ rt;
    assign mq[d]    = mout;

    always_ff @(posedge clk[R] or negedge rstn[d])
      if (!rstn[d]) begin
        rt <= 1'b0; wt1 <= 1'b0; wt2 <= 1'b0;
      end else begin
        wt1 <= wt;
        wt2 <= wt1;
        if (rd_m && mwait[d]) rt <= ~rt;
      end

    always_ff @(posedge clk[R]) if (rd_m && mwait[d]) mout <= mreg;
  end

  assign a_in_ok     = ~full[0];
  assign a_afull     = afull[0];
  assign a_out_ok    = ordy[1];
  assign a_aempty    = aempty[1];
  assign a_mail_wait = mwait[1];
  assign a_dout      = a_mbx ? mq[1] : fq[1];
  assign a_oe        = ~a_cs_n & ~a_wr;

  assign b_in_ok     = ~full[1];
  assign b_afull     = afull[1];
  assign b_out_ok    = ordy[0];
  assign b_aempty    = aempty[0];
  assign b_mail_wait = mwait[0];
  assign b_dout      = b_mbx ? mq[0] : fq[0];
  assign b_oe        = ~b_cs_n & ~b_wr;
endmodule

// File: rtl/bidir_mail_fifo_chk.sv
`timescale 1ns/1ps
module bidir_mail_fifo_chk (
  input logic clk_a,
  input logic clk_b,
  input logic rst1_n,
  input logic rst2_n,
  input logic fwft,
  input logic a_cs_n,
  input logic a_en,
  input logic a_wr,
  input logic a_mbx,
  input logic a_in_ok,
  input logic a_afull,
  input logic a_mail_wait,
  input logic b_cs_n,
  input logic b_en,
  input logic b_wr,
  input logic b_mbx,
  input logic b_out_ok,
  input logic b_aempty,
  input logic b_mail_wait
);
  p_full_afull_r3: assert property (@(posedge clk_a) disable iff (!rst1_n)
    !a_in_ok |-> a_afull);

  p_afull_first_r6: assert property (@(posedge clk_a) disable iff (!rst1_n)
    $fell(a_in_ok) |-> $past(a_afull));

  p_empty_aempty_r4: assert property (@(posedge clk_b) disable iff (!rst1_n)
    (!fwft && !b_out_ok) |-> b_aempty);

  p_head_kept_r5: assert property (@(posedge clk_b) disable iff (!rst1_n)
    (fwft && b_out_ok && !(!b_cs_n && b_en && !b_wr && !b_mbx)) |=> b_out_ok);

  p_mail_clear_b_r7: assert property (@(posedge clk_b) disable iff (!rst1_n)
    (!b_cs_n && b_en && !b_wr && b_mbx && b_mail_wait) |=> !b_mail_wait);

  p_mail_clear_a_r7: assert property (@(posedge clk_a) disable iff (!rst2_n)
    (!a_cs_n && a_en && !a_wr && a_mbx && a_mail_wait) |=> !a_mail_wait);
endmodule

bind bidir_mail_fifo bidir_mail_fifo_chk u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n), .fwft(fwft),
  .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
  .a_in_ok(a_in_ok), .a_afull(a_afull), .a_mail_wait(a_mail_wait),
  .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx),
  .b_out_ok(b_out_ok), .b_aempty(b_aempty), .b_mail_wait(b_mail_wait)
);

// File: tb/bidir_mail_fifo_tb.sv
`timescale 1ns/1ps
module bidir_mail_fifo_tb;
  localparam int W = 36;
  localparam int D = 32;

  logic clk_a = 0, clk_b = 0, rst1_n = 0, rst2_n = 0, fwft = 0;
  logic [1:0] fs_sel = 2'b10;
  logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mbx = 0;
  logic b_cs_n = 1, b_en = 0, b_wr = 0, b_mbx = 0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, a_in_ok, a_afull, a_out_ok, a_aempty, a_mail_wait;
  logic b_oe, b_in_ok, b_afull, b_out_ok, b_aempty, b_mail_wait;

  int tests = 0, fails = 0;
  bit hung = 0;
  logic [W-1:0] q1[$], q2[$];

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  bidir_mail_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .fwft(fwft), .fs_sel(fs_sel),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx), .a_din(a_din),
    .a_dout(a_dout), .a_oe(a_oe), .a_in_ok(a_in_ok), .a_afull(a_afull),
    .a_out_ok(a_out_ok), .a_aempty(a_aempty), .a_mail_wait(a_mail_wait),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx), .b_din(b_din),
    .b_dout(b_dout), .b_oe(b_oe), .b_in_ok(b_in_ok), .b_afull(b_afull),
    .b_out_ok(b_out_ok), .b_aempty(b_aempty), .b_mail_wait(b_mail_wait)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_dirs(input bit r1, input bit r2, input logic [1:0] fs, input bit ff);
    @(negedge clk_b);
    fs_sel = fs; fwft = ff;
    if (r1) begin rst1_n = 0; q1.delete(); end
    if (r2) begin rst2_n = 0; q2.delete(); end
    repeat (4) @(negedge clk_b);
    rst1_n = 1; rst2_n = 1;
    repeat (2) @(negedge clk_b);
  endtask

  task automatic a_put(input logic [W-1:0] v, input bit m);
    @(negedge clk_a);
    a_cs_n = 0; a_en = 1; a_wr = 1; a_mbx = m; a_din = v;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_mbx = 0;
  endtask

  task automatic b_put(input logic [W-1:0] v, input bit m);
    @(negedge clk_b);
    b_cs_n = 0; b_en = 1; b_wr = 1; b_mbx = m; b_din = v;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0; b_mbx = 0;
  endtask

  task automatic b_get(output logic [W-1:0] v, input bit m);
    bit ok = 0;
    v = 'x;
    @(negedge clk_b);
    for (int i = 0; i < 40; i++) begin
      if (m ? b_mail_wait : b_out_ok) begin ok = 1; break; end
      @(negedge clk_b);
    end
    if (!ok) return;
    if (fwft && !m) v = b_dout;
    b_cs_n = 0; b_en = 1; b_wr = 0; b_mbx = m;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0;
    if (!(fwft && !m)) v = b_dout;
    b_mbx = 0;
  endtask

  task automatic a_get(output logic [W-1:0] v, input bit m);
    bit ok = 0;
    v = 'x;
    @(negedge clk_a);
    for (int i = 0; i < 60; i++) begin
      if (m ? a_mail_wait : a_out_ok) begin ok = 1; break; end
      @(negedge clk_a);
    end
    if (!ok) return;
    if (fwft && !m) v = a_dout;
    a_cs_n = 0; a_en = 1; a_wr = 0; a_mbx = m;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0;
    if (!(fwft && !m)) v = a_dout;
    a_mbx = 0;
  endtask

  task automatic fill_a(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      q1.push_back(base + W'(i));
      a_put(base + W'(i), 0);
    end
  endtask

  task automatic drain_b(input int n, input string req);
    logic [W-1:0] got;
    for (int i = 0; i < n; i++) begin
      b_get(got, 0);
      chk(req, got, q1.size() ? q1.pop_front() : 'x);
    end
  endtask

  // scoreboard: driver pushes, monitor pops as words emerge
  task automatic stream(input bit ab, input int n, input logic [W-1:0] base);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          if (ab) begin q1.push_back(base + W'(i)); a_put(base + W'(i), 0); end
          else    begin q2.push_back(base + W'(i)); b_put(base + W'(i), 0); end
        end
      end
      begin
        logic [W-1:0] got;
        for (int i = 0; i < n; i++) begin
          if (ab) begin b_get(got, 0); chk("R1 order A->B", got, q1.size() ? q1.pop_front() : 'x); end
          else    begin a_get(got, 0); chk("R2 order B->A", got, q2.size() ? q2.pop_front() : 'x); end
        end
      end
    join
  endtask

  task automatic run();
    logic [W-1:0] got;
    reset_dirs(1, 1, 2'b10, 0);
    // R9 reset state
    chk("R9 a_in_ok", W'(a_in_ok), 1);
    chk("R9 b_out_ok", W'(b_out_ok), 0);
    chk("R9 b_aempty", W'(b_aempty), 1);
    chk("R9 a_afull", W'(a_afull), 0);
    chk("R9 mail waits", W'({a_mail_wait, b_mail_wait}), 0);
    chk("R9 a_out_ok", W'(a_out_ok), 0);

    // R10 output enable
    @(negedge clk_a); a_cs_n = 0; a_wr = 0; a_en = 0; #1;
    chk("R10 oe read sel", W'(a_oe), 1);
    a_cs_n = 1; #1; chk("R10 oe deselected", W'(a_oe), 0);
    a_cs_n = 0; a_wr = 1; #1; chk("R10 oe write", W'(a_oe), 0);
    a_cs_n = 1; a_wr = 0;

    // R11 gated accesses
    @(negedge clk_a); a_cs_n = 1; a_en = 1; a_wr = 1; a_din = 36'h111;
    @(negedge clk_a); a_cs_n = 0; a_en = 0; a_mbx = 1;
    @(negedge clk_a); a_cs_n = 1; a_wr = 0; a_mbx = 0;
    repeat (8) @(negedge clk_b);
    chk("R11 no queue write", W'(b_out_ok), 0);
    chk("R11 no mail write", W'(b_mail_wait), 0);

    stream(1, 20, 36'hA_0000_0100);
    stream(0, 12, 36'hB_0000_0200);

    // R3 full and overflow
    fill_a(D, 36'h3_0000_0000);
    chk("R3 in_ok low at full", W'(a_in_ok), 0);
    chk("R3 afull at full", W'(a_afull), 1);
    a_put(36'hBAD, 0);
    drain_b(D, "R3 data after full");
    repeat (8) @(negedge clk_b);
    chk("R3 overflow word dropped", W'(b_out_ok), 0);
    // R4 read of empty queue
    @(negedge clk_b); b_cs_n = 0; b_en = 1; b_wr = 0;
    @(negedge clk_b); b_cs_n = 1; b_en = 0;
    chk("R4 dout held on empty read", b_dout, 36'h3_0000_0000 + W'(D - 1));
    fill_a(1, 36'h4_0000_0044);
    drain_b(1, "R4 next word after empty read");

    // R6 thresholds, code 10 = 8 words
    fill_a(8, 36'h6_0000_0000);
    repeat (6) @(negedge clk_b);
    chk("R6 aempty at 8 (off 8)", W'(b_aempty), 1);
    fill_a(1, 36'h6_0000_0008);
    repeat (6) @(negedge clk_b);
    chk("R6 aempty at 9 (off 8)", W'(b_aempty), 0);
    fill_a(14, 36'h6_0000_0009);
    chk("R6 afull at 23 (off 8)", W'(a_afull), 0);
    fill_a(1, 36'h6_0000_0017);
    chk("R6 afull at 24 (off 8)", W'(a_afull), 1);
    drain_b(24, "R6 data");
    // code 00 = 16 words
    reset_dirs(1, 1, 2'b00, 0);
    fill_a(15, 36'h7_0000_0000);
    repeat (6) @(negedge clk_b);
    chk("R6 afull at 15 (off 16)", W'(a_afull), 0);
    fill_a(1, 36'h7_0000_000F);
    repeat (6) @(negedge clk_b);
    chk("R6 afull at 16 (off 16)", W'(a_afull), 1);
    chk("R6 aempty at 16 (off 16)", W'(b_aempty), 1);
    fill_a(1, 36'h7_0000_0010);
    repeat (6) @(negedge clk_b);
    chk("R6 aempty at 17 (off 16)", W'(b_aempty), 0);
    reset_dirs(1, 1, 2'b10, 0);

    // R7 mailboxes both ways
    a_put(36'hC_AFE0_0001, 1);
    repeat (6) @(negedge clk_b);
    chk("R7 b_mail_wait set", W'(b_mail_wait), 1);
    b_get(got, 1);
    chk("R7 mail A->B data", got, 36'hC_AFE0_0001);
    chk("R7 b_mail_wait cleared", W'(b_mail_wait), 0);
    chk("R7 queue untouched", W'(b_out_ok), 0);
    b_put(36'hD_00D0_0002, 1);
    a_get(got, 1);
    chk("R7 mail B->A data", got, 36'hD_00D0_0002);
    // R8 write to full mailbox dropped
    a_put(36'h8_0000_0001, 1);
    a_put(36'h8_0000_0002, 1);
    b_get(got, 1);
    chk("R8 first mail kept", got, 36'h8_0000_0001);
    repeat (10) @(negedge clk_b);
    chk("R8 second mail dropped", W'(b_mail_wait), 0);

    // R9 independent resets
    fill_a(3, 36'h9_0000_0000);
    q2.push_back(36'h9_1000_0000); b_put(36'h9_1000_0000, 0);
    q2.push_back(36'h9_1000_0001); b_put(36'h9_1000_0001, 0);
    a_put(36'h9_2000_0000, 1);
    reset_dirs(1, 0, 2'b10, 0);
    chk("R9 dir1 cleared", W'(b_out_ok), 0);
    chk("R9 mail1 cleared", W'(b_mail_wait), 0);
    chk("R9 dir1 in_ok", W'(a_in_ok), 1);
    for (int i = 0; i < 2; i++) begin
      a_get(got, 0);
      chk("R9 dir2 survives", got, q2.size() ? q2.pop_front() : 'x);
    end

    // R5 fall-through timing
    reset_dirs(1, 1, 2'b10, 1);
    a_put(36'h5_0000_00F0, 0);
    repeat (8) @(negedge clk_b);
    chk("R5 out_ok without read", W'(b_out_ok), 1);
    chk("R5 word shown without read", b_dout, 36'h5_0000_00F0);
    b_get(got, 0);
    chk("R5 first word", got, 36'h5_0000_00F0);
    stream(1, 12, 36'h5_0000_0100);
    stream(0, 10, 36'h5_0000_0200);
  endtask

  initial begin
    fork
      run();
      begin repeat (100000) @(posedge clk_a); hung = 1; end
    join_any
    disable fork;
    if (hung) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule